// File: doc/BRIEF.md
# Sign-Sampling QPSK Symbol Detector

This block recovers two-bit QPSK symbols from raw signed ADC samples. It does not mix the input with a local carrier and does not filter it. The converter runs at eight samples per carrier cycle. The block counts accepted samples into windows of eight, one window per transmitted phase. Inside each window it looks only at the sign of the first, third, fifth and seventh sample. Those four signs form a pattern, and the pattern is compared with one reference per carrier phase. A match gives a Gray-coded dibit. A pattern that matches no reference raises an error flag for that window.

The block also produces a sampling tick for the converter. The spacing of that tick is set by a divide input. An align input lets upstream framing logic restart the window count on a symbol boundary.

Top module: `qpsk_sign_detector`

## Requirements
- R1: A window is eight samples accepted with `sample_vld_i` high. Cycles with `sample_vld_i` low do not advance the window and have no effect on any output, however many of them fall inside a window.
- R2: Window positions are numbered 0 to 7 in arrival order. Only positions 0, 2, 4 and 6 set polarities, and a sample at any other position has no effect on the decision. A sample below zero is negative, and a sample equal to zero or above zero is positive. The full signed range counts, including the most negative code.
- R3: Polarity bit k is 1 when the sample at position 2k is negative. The 4-bit pattern {bit3,bit2,bit1,bit0} is mapped as follows: 4'b1100 gives 2'b00, 4'b0110 gives 2'b01, 4'b0011 gives 2'b11, and 4'b1001 gives 2'b10.
- R4: Any other pattern raises `sym_err_o` for the same single cycle as `sym_vld_o`, and `sym_o` keeps the last matched dibit.
- R5: When `align_i` is high, the window count restarts. A sample accepted in that same cycle becomes position 0. When `align_i` is high with no sample, the next accepted sample is position 0.
- R6: `sym_vld_o` is high for exactly one cycle, in the cycle after the edge that accepts position 7. `sym_o` is updated at that same edge.
- R7: `sample_tick_o` pulses for one cycle once every `div_i`+1 clock cycles, while `div_i` is held constant. When `div_i` is 0, it stays high every cycle.
- R8: After reset, `sym_vld_o`, `sym_err_o` and `sym_o` are 0, and the window count starts at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Tick divide value; the tick period is div_i+1 cycles |
| sample_tick_o | output | 1 | Sampling tick for the converter |
| sample_vld_i | input | 1 | Sample present on sample_i this cycle |
| sample_i | input | SAMPLE_W | Signed two's-complement sample |
| align_i | input | 1 | Restart the window count |
| sym_vld_o | output | 1 | One-cycle pulse at the end of each window |
| sym_o | output | 2 | Last matched Gray-coded dibit |
| sym_err_o | output | 1 | Window pattern matched no phase |

## Verification
The bench builds the block with SAMPLE_W of 8 and DIV_W of 4. With an 8-bit sample, the extreme codes -128 and 127 and exact zeros can be driven on purpose. With a 4-bit divider, both ends of the tick range are reachable: 0 gives a tick every cycle and 15 gives a 16-cycle period. The bench sends ideal sine windows at all four phases. It also sends windows with gaps, zeros at the sampled positions, junk at the unused positions, random invalid windows, and realignment in the middle of a window.

// File: rtl/qsd_pkg.sv
package qsd_pkg;
    localparam int WIN_LEN = 8;
    localparam int SEL_N   = WIN_LEN / 2;
    localparam int CNT_W   = $clog2(WIN_LEN);

    typedef logic [SEL_N-1:0] pol_t;
    typedef logic [1:0]       dibit_t;

    // Sign pattern expected for carrier phase index i (bit k = position 2k negative)
    function automatic pol_t ref_pattern(input int i);
        case (i)
            0:       return 4'b1100;
            1:       return 4'b0110;
            2:       return 4'b0011;
            3:       return 4'b1001;
            default: return '0;
        endcase
    endfunction

    // Gray-coded dibit for phase index i
    function automatic dibit_t ref_dibit(input int i);
        case (i)
            0:       return 2'b00;
            1:       return 2'b01;
            2:       return 2'b11;
            3:       return 2'b10;
            default: return 2'b00;
        endcase
    endfunction
endpackage

// File: rtl/qsd_tick_gen.sv
module qsd_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } tick_state_t;

    tick_state_t s_d, s_q;
    localparam logic [DIV_W-1:0] CNT_ONE = 1;

    always_comb begin
        s_d      = s_q;
        s_d.tick = (s_q.cnt >= div_i);
        s_d.cnt  = s_d.tick ? '0 : s_q.cnt + CNT_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o = s_q.tick;
endmodule

// File: rtl/qsd_window.sv
module qsd_window
    import qsd_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       vld_i,
    input  logic                       align_i,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    output logic                       done_o,
    output pol_t                       pat_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        pol_t             pol;
    } win_state_t;

    localparam logic [CNT_W-1:0] POS_ONE  = 1;
    localparam logic [CNT_W-1:0] POS_LAST = CNT_W'(WIN_LEN - 1);

    win_state_t       s_d, s_q;
    logic [CNT_W-1:0] pos;
    logic             neg;

    assign neg = (sample_i < 0);

    always_comb begin
        s_d    = s_q;
        done_o = 1'b0;
        pos    = align_i ? '0 : s_q.cnt;
        if (vld_i) begin
            if (!pos[0]) s_d.pol[pos[CNT_W-1:1]] = neg;
            s_d.cnt = pos + POS_ONE;
            done_o  = (pos == POS_LAST);
        end else if (align_i) begin
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Position 6 was captured before position 7 arrives, so the pattern is complete
    assign pat_o = s_q.pol;
endmodule

// File: rtl/qsd_matcher.sv
module qsd_matcher
    import qsd_pkg::*;
(
    input  pol_t   pat_i,
    output logic   hit_o,
    output dibit_t sym_o
);
    logic [SEL_N-1:0] hit;

    for (genvar i = 0; i < SEL_N; i++) begin : g_ref
        assign hit[i] = (pat_i == ref_pattern(i));
    end

    always_comb begin
        sym_o = '0;
        for (int i = 0; i < SEL_N; i++) begin
            if (hit[i]) sym_o = sym_o | ref_dibit(i);
        end
    end

    assign hit_o = |hit;
endmodule

// File: rtl/qpsk_sign_detector.sv
module qpsk_sign_detector
    import qsd_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int DIV_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DIV_W-1:0]           div_i,
    output logic                       sample_tick_o,
    input  logic                       sample_vld_i,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic                       align_i,
    output logic                       sym_vld_o,
    output logic [1:0]                 sym_o,
    output logic                       sym_err_o
);
    typedef struct packed {
        dibit_t sym;
        logic   vld;
        logic   err;
    } out_state_t;

    out_state_t o_d, o_q;
    logic       win_done;
    pol_t       win_pat;
    logic       pat_hit;
    dibit_t     pat_sym;

    qsd_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (div_i),
        .tick_o (sample_tick_o)
    );

    qsd_window #(.SAMPLE_W(SAMPLE_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_i    (sample_vld_i),
        .align_i  (align_i),
        .sample_i (sample_i),
        .done_o   (win_done),
        .pat_o    (win_pat)
    );

    qsd_matcher u_match (
        .pat_i (win_pat),
        .hit_o (pat_hit),
        .sym_o (pat_sym)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = win_done;
        o_d.err = win_done && !pat_hit;
        if (win_done && pat_hit) o_d.sym = pat_sym;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign sym_vld_o = o_q.vld;
    assign sym_o     = o_q.sym;
    assign sym_err_o = o_q.err;
endmodule

// File: rtl/qsd_checker.sv
module qsd_checker #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div_i,
    input logic             sample_tick_o,
    input logic             sample_vld_i,
    input logic             sym_vld_o,
    input logic [1:0]       sym_o,
    input logic             sym_err_o
);
    assert_vld_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld_o |=> !sym_vld_o);

    assert_vld_after_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld_o |-> $past(sample_vld_i));

    assert_err_with_vld_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sym_err_o |-> sym_vld_o);

    assert_err_holds_sym_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sym_err_o |-> $stable(sym_o));

    assert_tick_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick_o && div_i != '0) |=> (div_i == '0 || !sample_tick_o));

    assert_tick_every_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (div_i == '0) |=> sample_tick_o);

    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!sym_vld_o && !sym_err_o && sym_o == 2'b00));
endmodule

bind qpsk_sign_detector qsd_checker #(.DIV_W(DIV_W)) u_qsd_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .div_i         (div_i),
    .sample_tick_o (sample_tick_o),
    .sample_vld_i  (sample_vld_i),
    .sym_vld_o     (sym_vld_o),
    .sym_o         (sym_o),
    .sym_err_o     (sym_err_o)
);

// File: tb/test_qpsk_sign_detector.sv
`timescale 1ns/1ps
module test_qpsk_sign_detector;
    localparam int SW = 8;
    localparam int DW = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [DW-1:0]        div = 4'd3;
    logic                 tick;
    logic                 vld = 1'b0;
    logic signed [SW-1:0] smp = '0;
    logic                 align = 1'b0;
    logic                 sym_vld;
    logic [1:0]           sym;
    logic                 sym_err;

    int    n_vec = 0;
    int    n_bad = 0;
    string tag = "R8";
    bit    finished = 1'b0;

    always #2.5 clk = ~clk;

    qpsk_sign_detector #(.SAMPLE_W(SW), .DIV_W(DW)) i_qpsk_sign_detector (
        .clk           (clk),
        .rst_n         (rst_n),
        .div_i         (div),
        .sample_tick_o (tick),
        .sample_vld_i  (vld),
        .sample_i      (smp),
        .align_i       (align),
        .sym_vld_o     (sym_vld),
        .sym_o         (sym),
        .sym_err_o     (sym_err)
    );

    // ---------------- behavioural reference ----------------
    int m_pos = 0;
    bit m_neg[4];
    bit exp_vld = 0, exp_err = 0;
    int exp_sym = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; exp_vld = 0; exp_err = 0; exp_sym = 0;
        end else begin
            exp_vld = 0; exp_err = 0;
            if (align) m_pos = 0;
            if (vld) begin
                if (m_pos % 2 == 0) m_neg[m_pos / 2] = (int'(smp) < 0);
                if (m_pos == 7) begin
                    int code;
                    exp_vld = 1;
                    code = m_neg[0] + 2 * m_neg[1] + 4 * m_neg[2] + 8 * m_neg[3];
                    case (code)
                        12: exp_sym = 0;
                        6:  exp_sym = 1;
                        3:  exp_sym = 3;
                        9:  exp_sym = 2;
                        default: exp_err = 1;
                    endcase
                end
                m_pos = (m_pos + 1) % 8;
            end
        end
    end

    // ---------------- per-cycle compare ----------------
    int cyc = 0, last_tick = -1, last_div = 3;

    always @(negedge clk) begin
        cyc++;
        if (!finished) begin
            n_vec++;
            if (sym_vld !== exp_vld) begin
                n_bad++;
                $display("FAIL R6 R1 [%s] sym_vld=%0b expected %0b at cycle %0d", tag, sym_vld, exp_vld, cyc);
            end
            if (sym_err !== exp_err) begin
                n_bad++;
                $display("FAIL R4 [%s] sym_err=%0b expected %0b at cycle %0d", tag, sym_err, exp_err, cyc);
            end
            if (int'(sym) != exp_sym) begin
                n_bad++;
                $display("FAIL R3 [%s] sym=%0d expected %0d at cycle %0d", tag, sym, exp_sym, cyc);
            end
            if (rst_n) begin
                if (int'(div) != last_div) begin
                    last_div = int'(div);
                    last_tick = -1;
                end else if (tick) begin
                    if (last_tick >= 0) begin
                        n_vec++;
                        if (cyc - last_tick != last_div + 1) begin
                            n_bad++;
                            $display("FAIL R7 tick interval=%0d expected %0d", cyc - last_tick, last_div + 1);
                        end
                    end
                    last_tick = cyc;
                end
            end else begin
                last_tick = -1;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic put(input int v, input bit valid, input bit al);
        @(negedge clk);
        smp   = v[SW-1:0];
        vld   = valid;
        align = al;
    endtask

    function automatic int wave(input int ph, input int n);
        real a;
        a = 3.14159265358979 * (real'(n) / 4.0 + 0.25 + real'(ph) / 2.0);
        return $rtoi(100.0 * $sin(a));
    endfunction

    task automatic send_phase(input int ph);
        for (int n = 0; n < 8; n++) put(wave(ph, n), 1, 0);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) put(0, 0, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R8: reset state observed by the per-cycle compare
        idle(4);
        @(negedge clk); rst_n = 1'b1;
        idle(3);

        // R3: all four phases, back to back
        tag = "R3";
        for (int r = 0; r < 3; r++)
            for (int ph = 0; ph < 4; ph++) send_phase(ph);
        send_phase(2); send_phase(0); send_phase(3); send_phase(1);
        idle(4);

        // R1: gaps inside windows must not disturb counting
        tag = "R1";
        for (int ph = 0; ph < 4; ph++)
            for (int n = 0; n < 8; n++) begin
                put(wave(ph, n), 1, 0);
                idle((n * 3 + ph) % 4);
            end
        idle(2);

        // R2: zero counts positive, extremes, unused positions ignored
        tag = "R2";
        put(0, 1, 0); put(-128, 1, 0); put(0, 1, 0); put(-1, 1, 0);
        put(-1, 1, 0); put(127, 1, 0); put(-128, 1, 0); put(-90, 1, 0);
        put(-128, 1, 0); put(0, 1, 0); put(-1, 1, 0); put(0, 1, 0);
        put(-7, 1, 0); put(-7, 1, 0); put(127, 1, 0); put(-7, 1, 0);
        put(1, 1, 0); put(-128, 1, 0); put(0, 1, 0); put(-128, 1, 0);
        put(0, 1, 0); put(-128, 1, 0); put(0, 1, 0); put(-128, 1, 0);
        idle(2);

        // R4: invalid windows keep the last symbol
        tag = "R4";
        send_phase(1);
        for (int w = 0; w < 20; w++) begin
            for (int n = 0; n < 8; n++) put(int'($urandom_range(0, 255)) - 128, 1, 0);
            if (w % 5 == 0) send_phase(w % 4);
        end
        idle(2);

        // R5: realign mid-window, with and without a sample
        tag = "R5";
        for (int n = 0; n < 3; n++) put(-50, 1, 0);
        put(wave(3, 0), 1, 1);
        for (int n = 1; n < 8; n++) put(wave(3, n), 1, 0);
        for (int n = 0; n < 5; n++) put(wave(0, n), 1, 0);
        put(0, 0, 1);
        idle(2);
        send_phase(2);
        put(wave(1, 0), 1, 0); put(wave(1, 1), 1, 0);
        put(wave(0, 0), 1, 1);
        for (int n = 1; n < 8; n++) put(wave(0, n), 1, 0);
        idle(3);

        // R7: tick divide extremes
        tag = "R7";
        div = 4'd0;  idle(20);
        div = 4'd15; idle(70);
        div = 4'd7;  send_phase(3); idle(30);

        // R8: reset in the middle of a window
        tag = "R8";
        for (int n = 0; n < 4; n++) put(wave(2, n), 1, 0);
        @(negedge clk); rst_n = 1'b0; vld = 1'b0;
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        send_phase(1);
        idle(4);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule